// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block holds a pair of 32-bit command registers on a simple register bus: a low command word and a high command word. Software first programs the high word with the target processor's identifier. It then writes the low word with the vector, the delivery mode, the addressing mode, the level and trigger flags and a shorthand selector. The write to the low word is the send trigger. It captures a complete interrupt message and presents it on a valid/ready output toward the interrupt fabric.

A busy flag is shown as bit 12 of the low word. It is set by every accepted send and cleared by hardware in the cycle in which the fabric accepts the message. While it is set, any further write to the low word is dropped whole and the register keeps its earlier contents. No second message can then replace one that is still in flight. The shorthand selector can override the programmed target: the local identifier for a self send, or the all-ones broadcast identifier for the two broadcast forms. The exclude-self form also raises a separate flag on the message.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset both command words read as 0 and `msg_valid` is low.
- R2: A write at offset 0x310 stores only bits 31:24, which form the target identifier. All other bits of the high word read back as 0.
- R3: A write at offset 0x300 while idle stores bits 7:0 (vector), 10:8 (delivery mode), 11 (logical addressing), 14 (level), 15 (trigger) and 19:18 (shorthand). Other bits read back as 0. Bit 12 reads as the busy flag and is never taken from write data.
- R4: An accepted low-word write raises `msg_valid` on the next clock edge. The message fields come from the value just written, and the target comes from the high word as it stood at the time of the write.
- R5: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and every message field stays constant.
- R6: In the cycle with both `msg_valid` and `msg_ready` high, the busy flag clears. After that edge `msg_valid` is low and bit 12 of the low word reads as 0.
- R7: A low-word write made while the busy flag is set is discarded. The low word keeps its old value, and no further message is produced.
- R8: Shorthand 0 sends to the high word's identifier. Shorthand 1 sends to the `local_id` input sampled at the write.
- R9: Shorthands 2 and 3 both set the message target to 0xFF. `msg_excl_self` is 1 only for shorthand 3.
- R10: Writes to any offset other than 0x300 and 0x310 change nothing, and reads from such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| local_id | input | 8 | This processor's own identifier, used by the self shorthand |
| msg_valid | output | 1 | Message is being offered |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_dest | output | 8 | Target identifier |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Logical (1) or physical (0) target addressing |
| msg_level | output | 1 | Level flag |
| msg_trigger | output | 1 | Trigger mode flag |
| msg_excl_self | output | 1 | Broadcast that excludes the sender |

## Verification
The send path is exercised with each of the four shorthand values. Comparing the target against the high word, the `local_id` input and 0xFF separates the override paths, and the exclude flag separates the two broadcasts. Sends are made with the fabric always ready, with the fabric stalling for several cycles, and as back-to-back writes in consecutive cycles. This shows that a write is discarded exactly when a message is outstanding and that a stalled message does not move. Readbacks of the low word before, during and after a stall show the busy bit tracking the handshake. A write to an unmapped offset shows that nothing is launched or stored.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ID_W   = 8;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned MODE_W = 3;

    // Low command word field positions
    localparam int unsigned VEC_LSB   = 0;
    localparam int unsigned MODE_LSB  = 8;
    localparam int unsigned LOGIC_BIT = 11;
    localparam int unsigned BUSY_BIT  = 12;
    localparam int unsigned LEVEL_BIT = 14;
    localparam int unsigned TRIG_BIT  = 15;
    localparam int unsigned SH_LSB    = 18;
    // High command word target field
    localparam int unsigned DEST_LSB  = 24;

    localparam logic [ID_W-1:0] BCAST_ID = '1;

    typedef enum logic [1:0] {
        SH_NONE     = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL_INCL = 2'd2,
        SH_ALL_EXCL = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [ID_W-1:0]   dest;
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] dmode;
        logic              logical;
        logic              level;
        logic              trigger;
        logic              excl_self;
    } ipi_msg_t;

    // Writable bits of the low word (busy bit excluded)
    function automatic logic [WORD_W-1:0] low_wmask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < VEC_W; i++)  m[VEC_LSB + i]  = 1'b1;
        for (int i = 0; i < MODE_W; i++) m[MODE_LSB + i] = 1'b1;
        m[LOGIC_BIT]  = 1'b1;
        m[LEVEL_BIT]  = 1'b1;
        m[TRIG_BIT]   = 1'b1;
        m[SH_LSB]     = 1'b1;
        m[SH_LSB + 1] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] high_wmask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < ID_W; i++) m[DEST_LSB + i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode #(
    parameter int unsigned          ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]    LOW_OFF  = 12'h300,
    parameter logic [ADDR_W-1:0]    HIGH_OFF = 12'h310
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_low,
    output logic              sel_high,
    output logic              wr_low,
    output logic              wr_high
);

    always_comb begin
        sel_low  = (addr == LOW_OFF);
        sel_high = (addr == HIGH_OFF);
        wr_low   = wr_en && sel_low;
        wr_high  = wr_en && sel_high;
    end

endmodule

// File: rtl/ipi_msg_pack.sv
module ipi_msg_pack
    import ipi_pkg::*;
(
    input  logic [WORD_W-1:0] low_val,
    input  logic [ID_W-1:0]   high_dest,
    input  logic [ID_W-1:0]   local_id,
    output ipi_msg_t          msg
);

    shorthand_e sh;

    always_comb begin
        sh            = shorthand_e'(low_val[SH_LSB +: 2]);
        msg.vector    = low_val[VEC_LSB +: VEC_W];
        msg.dmode     = low_val[MODE_LSB +: MODE_W];
        msg.logical   = low_val[LOGIC_BIT];
        msg.level     = low_val[LEVEL_BIT];
        msg.trigger   = low_val[TRIG_BIT];
        msg.excl_self = 1'b0;
        msg.dest      = high_dest;
        unique case (sh)
            SH_NONE:     msg.dest = high_dest;
            SH_SELF:     msg.dest = local_id;
            SH_ALL_INCL: msg.dest = BCAST_ID;
            SH_ALL_EXCL: begin
                msg.dest      = BCAST_ID;
                msg.excl_self = 1'b1;
            end
            default:     msg.dest = high_dest;
        endcase
    end

endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_low,
    input  logic              wr_high,
    input  logic [WORD_W-1:0] wdata,
    input  ipi_msg_t          new_msg,
    input  logic              msg_ready,
    output logic [WORD_W-1:0] low_q,
    output logic [WORD_W-1:0] high_q,
    output logic              busy_q,
    output ipi_msg_t          msg_q
);

    localparam logic [WORD_W-1:0] LOW_MASK  = low_wmask();
    localparam logic [WORD_W-1:0] HIGH_MASK = high_wmask();

    typedef struct packed {
        logic [WORD_W-1:0] low;
        logic [WORD_W-1:0] high;
        logic              busy;
        ipi_msg_t          msg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && msg_ready) begin
            st_d.busy = 1'b0;
        end
        if (wr_high) begin
            st_d.high = wdata & HIGH_MASK;
        end
        if (wr_low && !st_q.busy) begin
            st_d.low  = wdata & LOW_MASK;
            st_d.busy = 1'b1;
            st_d.msg  = new_msg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_q  = st_q.low;
    assign high_q = st_q.high;
    assign busy_q = st_q.busy;
    assign msg_q  = st_q.msg;

endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
    import ipi_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] LOW_OFF  = 12'h300,
    parameter logic [ADDR_W-1:0] HIGH_OFF = 12'h310
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [7:0]        local_id,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_dest,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_dmode,
    output logic              msg_logical,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic              msg_excl_self
);

    logic              sel_low, sel_high, wr_low, wr_high;
    logic [WORD_W-1:0] low_q, high_q;
    logic              busy_q;
    ipi_msg_t          new_msg, msg_q;
    logic [WORD_W-1:0] busy_view;

    ipi_reg_decode #(
        .ADDR_W  (ADDR_W),
        .LOW_OFF (LOW_OFF),
        .HIGH_OFF(HIGH_OFF)
    ) dec_i (
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .sel_low (sel_low),
        .sel_high(sel_high),
        .wr_low  (wr_low),
        .wr_high (wr_high)
    );

    ipi_msg_pack pack_i (
        .low_val  (reg_wdata),
        .high_dest(high_q[DEST_LSB +: ID_W]),
        .local_id (local_id),
        .msg      (new_msg)
    );

    ipi_cmd_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_low   (wr_low),
        .wr_high  (wr_high),
        .wdata    (reg_wdata),
        .new_msg  (new_msg),
        .msg_ready(msg_ready),
        .low_q    (low_q),
        .high_q   (high_q),
        .busy_q   (busy_q),
        .msg_q    (msg_q)
    );

    always_comb begin
        busy_view           = '0;
        busy_view[BUSY_BIT] = busy_q;
        if (sel_low) begin
            reg_rdata = low_q | busy_view;
        end else if (sel_high) begin
            reg_rdata = high_q;
        end else begin
            reg_rdata = '0;
        end
    end

    assign msg_valid     = busy_q;
    assign msg_dest      = msg_q.dest;
    assign msg_vector    = msg_q.vector;
    assign msg_dmode     = msg_q.dmode;
    assign msg_logical   = msg_q.logical;
    assign msg_level     = msg_q.level;
    assign msg_trigger   = msg_q.trigger;
    assign msg_excl_self = msg_q.excl_self;

endmodule

// File: rtl/ipi_cmd_sender_chk.sv
module ipi_cmd_sender_chk #(
    parameter int unsigned       ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] LOW_OFF = 12'h300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [7:0]        msg_dest,
    input logic [7:0]        msg_vector,
    input logic [2:0]        msg_dmode,
    input logic              msg_excl_self
);

    // R6
    handshake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready |=> !msg_valid);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest)
            && $stable(msg_vector) && $stable(msg_dmode) && $stable(msg_excl_self));

    // R4
    launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(reg_wr_en) && ($past(reg_addr) == LOW_OFF));

    // R3
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == LOW_OFF) |-> (reg_rdata[12] == msg_valid));

    // R9
    bcast_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_excl_self |-> (msg_dest == 8'hFF));

endmodule

bind ipi_cmd_sender ipi_cmd_sender_chk #(
    .ADDR_W (ADDR_W),
    .LOW_OFF(LOW_OFF)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_dest     (msg_dest),
    .msg_vector   (msg_vector),
    .msg_dmode    (msg_dmode),
    .msg_excl_self(msg_excl_self)
);

// File: tb/ipi_cmd_sender_tb_top.sv
`timescale 1ns/1ps
module ipi_cmd_sender_tb_top;

    localparam logic [11:0] LOW  = 12'h300;
    localparam logic [11:0] HIGH = 12'h310;

    typedef struct packed {
        logic [7:0] dest;
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       logical;
        logic       level;
        logic       trigger;
        logic       excl;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr_en = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  local_id = 8'h17;
    logic        msg_valid;
    logic        msg_ready = 0;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_dmode;
    logic        msg_logical, msg_level, msg_trigger, msg_excl_self;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    logic [7:0]  exp_high_dest = '0;
    logic [31:0] exp_low = '0;
    bit   done = 0;

    always #5 clk = ~clk;

    ipi_cmd_sender dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .local_id(local_id),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_logical(msg_logical),
        .msg_level(msg_level), .msg_trigger(msg_trigger), .msg_excl_self(msg_excl_self)
    );

    function automatic logic [31:0] mk_low(logic [7:0] vec, logic [2:0] md,
                                           logic lg, logic lv, logic tr, logic [1:0] sh);
        return {12'h0, sh, 2'b00, tr, lv, 1'b0, 1'b0, lg, md, vec};
    endfunction

    function automatic exp_t predict(logic [31:0] w);
        exp_t e;
        e.vector  = w[7:0];
        e.dmode   = w[10:8];
        e.logical = w[11];
        e.level   = w[14];
        e.trigger = w[15];
        e.excl    = (w[19:18] == 2'd3);
        case (w[19:18])
            2'd0: e.dest = exp_high_dest;
            2'd1: e.dest = local_id;
            default: e.dest = 8'hFF;
        endcase
        return e;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: pushes the predicted message when the write will be taken
    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        if (a == HIGH) exp_high_dest = d[31:24];
        if (a == LOW && !msg_valid) begin
            sb_q.push_back(predict(d));
            exp_low = d & 32'h000C_CFFF;
        end
        @(posedge clk);
        #1 reg_wr_en = 0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #2 check(req, reg_rdata, exp);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops on each handshake, checks stall stability
    exp_t held;
    bit   stalled = 0;
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (stalled) begin
                    check("R5", {msg_valid, msg_dest, msg_vector, msg_dmode, msg_excl_self},
                          {1'b1, held.dest, held.vector, held.dmode, held.excl});
                end
                stalled = 0;
                if (msg_valid && msg_ready) begin
                    if (sb_q.size() == 0) begin
                        check("R7", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check("R4", {msg_dest, msg_vector, msg_dmode, msg_logical,
                                     msg_level, msg_trigger, msg_excl_self}, e);
                    end
                end else if (msg_valid) begin
                    stalled = 1;
                    held = {msg_dest, msg_vector, msg_dmode, msg_logical,
                            msg_level, msg_trigger, msg_excl_self};
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;
        // R1 reset state
        rd_chk(LOW, 32'h0, "R1");
        rd_chk(HIGH, 32'h0, "R1");
        check("R1", {31'h0, msg_valid}, 32'h0);

        // R2 high word masking
        wr_reg(HIGH, 32'hA5FF_FFFF);
        rd_chk(HIGH, 32'hA500_0000, "R2");

        // R8 shorthand 0, fabric always ready, busy bit in write data ignored
        msg_ready = 1;
        wr_reg(LOW, mk_low(8'h31, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0) | 32'hFFF0_3000);
        wait_cyc(3);
        rd_chk(LOW, 32'h0000_0031, "R3");

        // Stalled send: R3 busy view, R7 discard, R6 clear
        @(negedge clk) msg_ready = 0;
        wr_reg(LOW, mk_low(8'h42, 3'd4, 1'b1, 1'b1, 1'b1, 2'd0));
        rd_chk(LOW, exp_low | 32'h1000, "R3");
        wr_reg(LOW, mk_low(8'h99, 3'd1, 1'b0, 1'b0, 1'b0, 2'd2));
        rd_chk(LOW, exp_low | 32'h1000, "R7");
        wr_reg(HIGH, 32'h3C00_0000);   // changes target only for later sends
        wait_cyc(4);
        @(negedge clk) msg_ready = 1;
        wait_cyc(3);
        rd_chk(LOW, mk_low(8'h42, 3'd4, 1'b1, 1'b1, 1'b1, 2'd0), "R6");
        check("R6", {31'h0, msg_valid}, 32'h0);

        // R8 self shorthand
        local_id = 8'h17;
        wr_reg(LOW, mk_low(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1));
        wait_cyc(3);
        // R9 broadcast shorthands
        wr_reg(LOW, mk_low(8'h61, 3'd1, 1'b0, 1'b0, 1'b0, 2'd2));
        wait_cyc(3);
        wr_reg(LOW, mk_low(8'h72, 3'd2, 1'b1, 1'b0, 1'b1, 2'd3));
        wait_cyc(3);

        // R7 back-to-back writes: second one lands while busy
        wr_reg(LOW, mk_low(8'h81, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0));
        wr_reg(LOW, mk_low(8'h82, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0));
        wait_cyc(3);
        rd_chk(LOW, mk_low(8'h81, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), "R7");

        // R10 unmapped offset
        wr_reg(12'h320, 32'hFFFF_FFFF);
        rd_chk(12'h320, 32'h0, "R10");
        check("R10", {31'h0, msg_valid}, 32'h0);
        rd_chk(LOW, mk_low(8'h81, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), "R10");
        rd_chk(HIGH, 32'h3C00_0000, "R10");

        wait_cyc(3);
        check("R7", sb_q.size(), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule